// File: doc/BRIEF.md
# Parameter-Set Sequencer

The sequencer walks an accelerator through a contiguous range of stored parameter sets and a programmed number of passes over that range. For each set it reads a configuration word from an external memory and decodes the set's trigger source. It waits until that trigger is present, then copies the set's compute payload into a working register and starts the compute engine with a one-cycle start pulse. When the engine reports done, the sequencer emits the completion events for that set and moves on to the next index.

Four trigger sources are offered per set: start at once, a pending software request, a ping-pong buffer swap (only honoured while buffer sharing is on), and a pending bit of a 16-bit DMA request register chosen by the set. Software and DMA requests are latched inside the block and used up when accepted. On completion the block pulses a done-status set line for the set's index. If the set enables them, it also pulses an interrupt and a one-hot DMA channel request.

Top module: `pset_sequencer`

## Requirements
- R1: The block runs only while the enable key input equals 3'b111. Any other key value keeps it idle, with no configuration read and no start pulse.
- R2: Sets run in index order from the start index. Each index is one above the last, modulo 16. After the stop index has run, the next set is the start index again.
- R3: The loop count is sampled when the block leaves idle. A count N from 1 to 4094 gives exactly N full passes, after which the block stays quiet until it is disabled. A count of 0 causes no activity. A count of 0xFFF repeats the passes without end.
- R4: Each set costs exactly one configuration read at its own index. The word layout is: bits [2:0] trigger mode, [6:3] DMA source bit, [7] interrupt enable, [8] DMA request enable, [12:9] DMA channel, [28:13] compute payload.
- R5: Trigger mode 000 starts at once, and so do the unused codes 100 to 111. Mode 001 waits while no software request is pending.
- R6: Mode 010 starts only on a ping-pong swap pulse that arrives while buffer sharing is enabled. Swap pulses with sharing off are ignored.
- R7: Mode 011 waits until the pending DMA request bit selected by the set's source field is one. Other bits do not start it.
- R8: An accepted software or DMA request is cleared, so one request starts exactly one set.
- R9: The set's payload appears on the working output before the start pulse and stays constant until done. The start pulse lasts one cycle.
- R10: For each completed set, one cycle carries a one-hot done-status pulse at the set's index. In that same cycle the interrupt pulses if the set enables it, and the DMA request output pulses one-hot at the set's channel if DMA requests are enabled.
- R11: When the enable key leaves 3'b111, the block is idle from the next clock edge. All outputs read zero, including the working payload, and pending software and DMA requests are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en_key_i | input | 3 | Enable key; 3'b111 runs |
| start_idx_i | input | 4 | First set index of the range |
| stop_idx_i | input | 4 | Last set index of the range |
| loop_cnt_i | input | 12 | Pass count; 0 none, 0xFFF endless |
| share_en_i | input | 1 | ADC buffer sharing mode on |
| sw_trig_i | input | 1 | Software request pulse |
| dma_trig_i | input | 16 | DMA request pulses, one bit per source |
| pp_switch_i | input | 1 | Ping-pong buffer swap pulse |
| cfg_rd_data_i | input | 29 | Configuration word, valid one cycle after the read |
| done_i | input | 1 | Compute engine finished |
| cfg_rd_en_o | output | 1 | Configuration read strobe |
| cfg_rd_addr_o | output | 4 | Configuration read index |
| work_cfg_o | output | 16 | Working payload for the compute engine |
| start_o | output | 1 | Compute start pulse |
| irq_o | output | 1 | Completion interrupt pulse |
| dma_trig_o | output | 16 | One-hot DMA channel request pulse |
| done_set_o | output | 16 | One-hot done-status set pulse |

## Verification
Sequencing is tried on several ranges: a single set, a range with start below stop, a range that wraps past index 15, and a full sixteen-set sweep. These are run with one, two and three passes. Comparing the recorded done indices, events and payloads with an arithmetic model separates errors in advance and wrap from errors in pass counting. Each trigger mode is held without its trigger, then given a wrong trigger (a different DMA bit, or a swap pulse with sharing off), then given the right one. This separates waiting from firing, and a second set proves that one request is consumed per set. Endless looping, disabling mid-compute, wrong enable keys and requests made while disabled cover the stop and idle paths.

// File: rtl/pset_seq_pkg.sv
package pset_seq_pkg;
  localparam int CH_W = 4;
  localparam int N_CH = 1 << CH_W;

  localparam logic [2:0] TM_IMM = 3'd0;
  localparam logic [2:0] TM_SW  = 3'd1;
  localparam logic [2:0] TM_PP  = 3'd2;
  localparam logic [2:0] TM_DMA = 3'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_CAPT, S_WAIT, S_START, S_BUSY, S_FIN, S_HALT
  } seq_state_t;

  // control part of a configuration word, mode in the low bits
  typedef struct packed {
    logic [CH_W-1:0] dst;
    logic            dma_en;
    logic            irq_en;
    logic [CH_W-1:0] src;
    logic [2:0]      mode;
  } set_ctl_t;

  localparam int CTL_W = $bits(set_ctl_t);
endpackage

// File: rtl/pset_loop_ctl.sv
module pset_loop_ctl #(
  parameter int IDX_W  = 4,
  parameter int LOOP_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              init_i,
  input  logic              step_i,
  input  logic [IDX_W-1:0]  start_i,
  input  logic [IDX_W-1:0]  stop_i,
  input  logic [LOOP_W-1:0] loops_i,
  output logic [IDX_W-1:0]  idx_o,
  output logic              last_o
);
  localparam logic [LOOP_W-1:0] ENDLESS = '1;
  localparam logic [LOOP_W-1:0] ONE     = LOOP_W'(1);

  logic [IDX_W-1:0]  idx_q, first_q, stop_q;
  logic [LOOP_W-1:0] left_q;
  logic              inf_q;
  logic              at_stop;

  assign at_stop = (idx_q == stop_q);
  assign last_o  = at_stop && !inf_q && (left_q == ONE);
  assign idx_o   = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q   <= '0;
      first_q <= '0;
      stop_q  <= '0;
      left_q  <= '0;
      inf_q   <= 1'b0;
    end else if (init_i) begin
      idx_q   <= start_i;
      first_q <= start_i;
      stop_q  <= stop_i;
      left_q  <= loops_i;
      inf_q   <= (loops_i == ENDLESS);
    end else if (step_i) begin
      if (!at_stop) begin
        idx_q <= idx_q + 1'b1;
      end else begin
        idx_q <= first_q;
        if (!inf_q) left_q <= left_q - 1'b1;
      end
    end
  end

  // R3
  pass_left_chk: assert property (@(posedge clk) disable iff (rst)
    (step_i && !inf_q) |-> (left_q != '0));
endmodule

// File: rtl/pset_trig_unit.sv
module pset_trig_unit
  import pset_seq_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            clr_i,
  input  logic            sw_set_i,
  input  logic [N_CH-1:0] dma_set_i,
  input  logic            pp_i,
  input  logic            share_i,
  input  logic            wait_i,
  input  logic [2:0]      mode_i,
  input  logic [CH_W-1:0] src_i,
  output logic            fire_o
);
  logic            sw_pend;
  logic [N_CH-1:0] dma_pend;
  logic [N_CH-1:0] dma_take;
  logic            hit;
  logic            sw_take;

  always_comb begin
    case (mode_i)
      TM_SW:   hit = sw_pend;
      TM_PP:   hit = pp_i && share_i;
      TM_DMA:  hit = dma_pend[src_i];
      default: hit = 1'b1;
    endcase
  end

  assign fire_o   = wait_i && hit;
  assign sw_take  = fire_o && (mode_i == TM_SW);
  assign dma_take = (fire_o && (mode_i == TM_DMA)) ? (N_CH'(1) << src_i) : '0;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      sw_pend  <= 1'b0;
      dma_pend <= '0;
    end else begin
      sw_pend  <= sw_set_i | (sw_pend & ~sw_take);
      dma_pend <= dma_set_i | (dma_pend & ~dma_take);
    end
  end

  // R8
  sw_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_i && sw_pend && mode_i == TM_SW && !sw_set_i) |=> !sw_pend);

  // R8
  dma_consume_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_i && dma_pend[src_i] && mode_i == TM_DMA && !dma_set_i[src_i])
      |=> !dma_pend[$past(src_i)]);

  // R6
  pp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    (wait_i && mode_i == TM_PP && !share_i) |-> !fire_o);
endmodule

// File: rtl/pset_evt_out.sv
module pset_evt_out
  import pset_seq_pkg::*;
#(
  parameter int IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr_i,
  input  logic                    fire_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic                    irq_en_i,
  input  logic                    dma_en_i,
  input  logic [CH_W-1:0]         dst_i,
  output logic                    irq_o,
  output logic [N_CH-1:0]         dma_o,
  output logic [(1<<IDX_W)-1:0]   done_o
);
  localparam int NSETS = 1 << IDX_W;

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      irq_o  <= 1'b0;
      dma_o  <= '0;
      done_o <= '0;
    end else begin
      irq_o  <= fire_i && irq_en_i;
      dma_o  <= (fire_i && dma_en_i) ? (N_CH'(1) << dst_i) : '0;
      done_o <= fire_i ? (NSETS'(1) << idx_i) : '0;
    end
  end

  // R10
  evt_single_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o != '0) |=> (done_o == '0));
endmodule

// File: rtl/pset_sequencer.sv
module pset_sequencer
  import pset_seq_pkg::*;
#(
  parameter int IDX_W     = 4,
  parameter int LOOP_W    = 12,
  parameter int PAYLOAD_W = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [2:0]                   en_key_i,
  input  logic [IDX_W-1:0]             start_idx_i,
  input  logic [IDX_W-1:0]             stop_idx_i,
  input  logic [LOOP_W-1:0]            loop_cnt_i,
  input  logic                         share_en_i,
  input  logic                         sw_trig_i,
  input  logic [N_CH-1:0]              dma_trig_i,
  input  logic                         pp_switch_i,
  input  logic [CTL_W+PAYLOAD_W-1:0]   cfg_rd_data_i,
  input  logic                         done_i,
  output logic                         cfg_rd_en_o,
  output logic [IDX_W-1:0]             cfg_rd_addr_o,
  output logic [PAYLOAD_W-1:0]         work_cfg_o,
  output logic                         start_o,
  output logic                         irq_o,
  output logic [N_CH-1:0]              dma_trig_o,
  output logic [(1<<IDX_W)-1:0]        done_set_o
);
  localparam int NSETS  = 1 << IDX_W;
  localparam int WORD_W = CTL_W + PAYLOAD_W;
  localparam logic [2:0] RUN_KEY = 3'b111;

  seq_state_t           state_q, nxt;
  set_ctl_t             ctl_q;
  logic [PAYLOAD_W-1:0] pay_q, work_q;
  logic                 start_q;
  logic                 run, fire, last, init, step;
  logic [IDX_W-1:0]     idx;

  assign run  = (en_key_i == RUN_KEY);
  assign init = run && (state_q == S_IDLE) && (loop_cnt_i != '0);
  assign step = run && (state_q == S_FIN);

  always_comb begin
    nxt = state_q;
    if (!run) begin
      nxt = S_IDLE;
    end else begin
      case (state_q)
        S_IDLE:  if (loop_cnt_i != '0) nxt = S_FETCH;
        S_FETCH: nxt = S_CAPT;
        S_CAPT:  nxt = S_WAIT;
        S_WAIT:  if (fire) nxt = S_START;
        S_START: nxt = S_BUSY;
        S_BUSY:  if (done_i) nxt = S_FIN;
        S_FIN:   nxt = last ? S_HALT : S_FETCH;
        default: nxt = S_HALT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      ctl_q   <= '0;
      pay_q   <= '0;
      work_q  <= '0;
      start_q <= 1'b0;
    end else begin
      state_q <= nxt;
      start_q <= run && (state_q == S_START);
      if (state_q == S_CAPT) begin
        ctl_q <= cfg_rd_data_i[CTL_W-1:0];
        pay_q <= cfg_rd_data_i[WORD_W-1:CTL_W];
      end
      if (!run)
        work_q <= '0;
      else if (state_q == S_WAIT && fire)
        work_q <= pay_q;
    end
  end

  pset_loop_ctl #(.IDX_W(IDX_W), .LOOP_W(LOOP_W)) loop_i (
    .clk(clk), .rst(rst), .init_i(init), .step_i(step),
    .start_i(start_idx_i), .stop_i(stop_idx_i), .loops_i(loop_cnt_i),
    .idx_o(idx), .last_o(last)
  );

  pset_trig_unit trig_i (
    .clk(clk), .rst(rst), .clr_i(!run),
    .sw_set_i(sw_trig_i), .dma_set_i(dma_trig_i),
    .pp_i(pp_switch_i), .share_i(share_en_i),
    .wait_i(run && state_q == S_WAIT),
    .mode_i(ctl_q.mode), .src_i(ctl_q.src), .fire_o(fire)
  );

  pset_evt_out #(.IDX_W(IDX_W)) evt_i (
    .clk(clk), .rst(rst), .clr_i(!run), .fire_i(step),
    .idx_i(idx), .irq_en_i(ctl_q.irq_en), .dma_en_i(ctl_q.dma_en),
    .dst_i(ctl_q.dst),
    .irq_o(irq_o), .dma_o(dma_trig_o), .done_o(done_set_o)
  );

  assign cfg_rd_en_o   = (state_q == S_FETCH);
  assign cfg_rd_addr_o = idx;
  assign work_cfg_o    = work_q;
  assign start_o       = start_q;

  // R9
  start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    start_o |=> !start_o);

  // R9
  work_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (run && state_q == S_BUSY && $past(state_q) == S_BUSY) |-> $stable(work_cfg_o));

  // R10
  dma_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(dma_trig_o) && $onehot0(done_set_o));

  // R10
  irq_with_done_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_o || dma_trig_o != '0) |-> (done_set_o != '0));

  // R11
  off_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> (!start_o && !irq_o && dma_trig_o == '0 && done_set_o == '0
              && !cfg_rd_en_o && work_cfg_o == '0));
endmodule

// File: tb/pset_sequencer_tb_top.sv
module pset_sequencer_tb_top;
  localparam int WW = 29;

  logic        clk = 1'b0;
  logic        rst;
  logic [2:0]  en_key;
  logic [3:0]  start_idx, stop_idx;
  logic [11:0] loop_cnt;
  logic        share_en, sw_trig, pp_sw, done_i;
  logic [15:0] dma_trig;
  logic [WW-1:0] rd_data;
  logic        rd_en, start_o, irq_o;
  logic [3:0]  rd_addr;
  logic [15:0] work_cfg, dma_o, done_set;

  always #10 clk = ~clk;

  pset_sequencer dut_i (
    .clk(clk), .rst(rst), .en_key_i(en_key), .start_idx_i(start_idx),
    .stop_idx_i(stop_idx), .loop_cnt_i(loop_cnt), .share_en_i(share_en),
    .sw_trig_i(sw_trig), .dma_trig_i(dma_trig), .pp_switch_i(pp_sw),
    .cfg_rd_data_i(rd_data), .done_i(done_i),
    .cfg_rd_en_o(rd_en), .cfg_rd_addr_o(rd_addr), .work_cfg_o(work_cfg),
    .start_o(start_o), .irq_o(irq_o), .dma_trig_o(dma_o), .done_set_o(done_set)
  );

  logic [WW-1:0] mem [16];
  always @(posedge clk) if (rd_en) rd_data <= mem[rd_addr];

  int n_chk = 0, n_err = 0;
  int log_n = 0, st_n = 0, rd_cnt = 0, cd = 0;
  int log_idx [64];
  int log_irq [64];
  int log_dma [64];
  int log_pay [64];
  int rd_addr_log [64];

  function automatic int bit_of(logic [15:0] v);
    if ($countones(v) != 1) return 99;
    for (int b = 0; b < 16; b++) if (v[b]) return b;
    return 99;
  endfunction

  function automatic logic [WW-1:0] word(int i, logic [2:0] mode, int src);
    logic [15:0] pay;
    logic [3:0]  dst;
    pay = 16'hA000 + 16'(i * 17);
    dst = 4'((i * 3) % 16);
    return {pay, dst, 1'(i & 1), 1'((i >> 1) & 1), 4'(src), mode};
  endfunction

  always @(negedge clk) begin
    if (done_set != 0) begin
      if (log_n < 64) begin
        log_idx[log_n] = bit_of(done_set);
        log_irq[log_n] = int'(irq_o);
        log_dma[log_n] = int'(dma_o);
      end
      log_n++;
    end
    if (start_o) begin
      if (st_n < 64) log_pay[st_n] = int'(work_cfg);
      st_n++;
    end
    if (rd_en) begin
      if (rd_cnt < 64) rd_addr_log[rd_cnt] = int'(rd_addr);
      rd_cnt++;
    end
    done_i = 1'b0;
    if (start_o) cd = 3;
    else if (cd > 0) begin
      cd--;
      if (cd == 0) done_i = 1'b1;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cycles(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_log();
    log_n = 0; st_n = 0; rd_cnt = 0;
  endtask

  task automatic stop_all();
    @(negedge clk);
    en_key = 3'b000;
    cycles(3);
    clr_log();
  endtask

  task automatic fill_imm();
    for (int i = 0; i < 16; i++) mem[i] = word(i, 3'b000, 0);
  endtask

  task automatic go(int s, int e, int l);
    @(negedge clk);
    start_idx = 4'(s); stop_idx = 4'(e); loop_cnt = 12'(l);
    en_key = 3'b111;
  endtask

  task automatic seq_run(int s, int e, int l);
    int exp_idx [64];
    int n = 0;
    int guard = 0;
    for (int p = 0; p < l; p++) begin
      int k = s;
      forever begin
        exp_idx[n] = k; n++;
        if (k == e) break;
        k = (k + 1) % 16;
      end
    end
    go(s, e, l);
    while (log_n < n && guard < 3000) begin @(negedge clk); guard++; end
    cycles(40);
    chk("R3 pass count", log_n, n);
    chk("R4 read count", rd_cnt, n);
    for (int j = 0; j < n; j++) begin
      int ix = exp_idx[j];
      chk("R2 order", log_idx[j], ix);
      chk("R4 read index", rd_addr_log[j], ix);
      chk("R10 irq", log_irq[j], (ix >> 1) & 1);
      chk("R10 dma", log_dma[j], (ix & 1) ? (1 << ((ix * 3) % 16)) : 0);
      chk("R9 payload", log_pay[j], 16'hA000 + ix * 17);
    end
    stop_all();
  endtask

  task automatic pulse_sw();
    @(negedge clk); sw_trig = 1'b1;
    @(negedge clk); sw_trig = 1'b0;
  endtask

  task automatic pulse_dma(int b);
    @(negedge clk); dma_trig = 16'(1 << b);
    @(negedge clk); dma_trig = 16'h0;
  endtask

  task automatic pulse_pp();
    @(negedge clk); pp_sw = 1'b1;
    @(negedge clk); pp_sw = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int guard;
    int held;
    rst = 1'b1; en_key = 3'b000; start_idx = 0; stop_idx = 0; loop_cnt = 0;
    share_en = 1'b0; sw_trig = 1'b0; dma_trig = 16'h0; pp_sw = 1'b0;
    done_i = 1'b0; rd_data = '0;
    fill_imm();
    cycles(5);
    rst = 1'b0;
    cycles(2);
    // R11 reset state: all outputs quiet
    chk("R11 reset start", start_o, 0);
    chk("R11 reset irq", irq_o, 0);
    chk("R11 reset dma", dma_o, 0);
    chk("R11 reset done", done_set, 0);
    chk("R11 reset read", rd_en, 0);
    clr_log();

    // R1 wrong enable keys
    @(negedge clk); start_idx = 0; stop_idx = 3; loop_cnt = 1; en_key = 3'b110;
    cycles(50);
    chk("R1 key 110 reads", rd_cnt, 0);
    en_key = 3'b011;
    cycles(50);
    chk("R1 key 011 starts", st_n, 0);
    stop_all();

    // R3 zero loop count
    go(0, 3, 0);
    cycles(50);
    chk("R3 zero count reads", rd_cnt, 0);
    chk("R3 zero count done", log_n, 0);
    stop_all();

    // R2 R3 R4 R9 R10 range sweeps
    seq_run(2, 5, 2);
    seq_run(0, 0, 1);
    seq_run(14, 1, 1);
    seq_run(3, 3, 3);
    seq_run(7, 6, 1);

    // R5 reserved code behaves as immediate
    mem[4] = word(4, 3'b101, 0);
    seq_run(4, 4, 1);
    fill_imm();

    // R5 R8 software trigger, one request per set
    mem[0] = word(0, 3'b001, 0);
    mem[1] = word(1, 3'b001, 0);
    go(0, 1, 1);
    cycles(40);
    chk("R5 sw wait", log_n, 0);
    pulse_sw();
    cycles(40);
    chk("R8 one sw set", log_n, 1);
    pulse_sw();
    cycles(40);
    chk("R8 second sw set", log_n, 2);
    chk("R2 sw order", log_idx[1], 1);
    stop_all();

    // R11 request while disabled is dropped
    pulse_sw();
    cycles(3);
    go(0, 0, 1);
    cycles(40);
    chk("R11 stale sw", log_n, 0);
    stop_all();
    fill_imm();

    // R7 DMA trigger on selected bit
    mem[2] = word(2, 3'b011, 5);
    go(2, 2, 1);
    cycles(30);
    pulse_dma(4);
    cycles(40);
    chk("R7 wrong dma bit", log_n, 0);
    pulse_dma(5);
    cycles(40);
    chk("R7 right dma bit", log_n, 1);
    stop_all();
    @(negedge clk);
    start_idx = 2; stop_idx = 2; loop_cnt = 2; en_key = 3'b111; dma_trig = 16'h0020;
    @(negedge clk); dma_trig = 16'h0;
    cycles(60);
    chk("R8 early dma one set", log_n, 1);
    stop_all();
    fill_imm();

    // R6 ping-pong swap gated by sharing
    mem[3] = word(3, 3'b010, 0);
    share_en = 1'b0;
    go(3, 3, 1);
    cycles(30);
    pulse_pp();
    cycles(40);
    chk("R6 swap without sharing", log_n, 0);
    share_en = 1'b1;
    pulse_pp();
    cycles(40);
    chk("R6 swap with sharing", log_n, 1);
    stop_all();
    share_en = 1'b0;
    fill_imm();

    // R3 endless loop, then R11 disable during compute
    go(0, 2, 12'hFFF);
    cycles(600);
    chk("R3 endless", (log_n > 40) ? 1 : 0, 1);
    guard = 0;
    while (!start_o && guard < 100) begin @(negedge clk); guard++; end
    en_key = 3'b000;
    @(negedge clk);
    chk("R11 start drop", start_o, 0);
    chk("R11 read drop", rd_en, 0);
    chk("R11 work drop", work_cfg, 0);
    held = log_n;
    cycles(30);
    chk("R11 no late done", log_n, held);
    chk("R11 irq quiet", irq_o, 0);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule